// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block controls the low-power resting state of a synchronous memory array. A sleep request arrives from outside the clock domain, active high, and passes through a chain of synchronising flip-flops before it reaches a four-state sequencer. The sequencer walks from awake, through a fixed-length entry phase, into the resting state. When the request goes away it walks back out through a fixed-length exit phase. The array is told to rest only while the sequencer sits in the resting state, and the stored contents are never cleared.

From the moment entry begins until a recovery period after exit has run out, the block blocks new accesses. An access that is still in flight on the clock edge where entry begins is flagged as void for one cycle, so that its completion is not relied on. Two situations count as protocol violations and set a sticky error flag: a chip select or either address strobe asserted during the entry phase, and one asserted during the recovery period after the request is released. The flag stays set until reset.

Top module: `lp_sleep_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `acc_block`, `sleep_active`, `acc_void` and `proto_err` are all 0. Reset also clears a `proto_err` that was set before.
- R2: A `sleep_req` that rises before clock edge k, with everything awake, makes `acc_block` go to 1 after edge k+2: two synchroniser flops, then the sequencer register.
- R3: Entry lasts ENT_CYC cycles (default 2). `sleep_active` goes to 1 exactly ENT_CYC edges after `acc_block` rises.
- R4: When `sleep_req` falls before edge m while resting, `sleep_active` goes to 0 after edge m+2. The exit phase then lasts EXIT_CYC cycles (default 2).
- R5: `acc_block` is 1 in every state except awake. It is also 1 until REC_CYC edges after `sleep_active` falls. It goes to 0 exactly at that point, as long as REC_CYC is at least EXIT_CYC.
- R6: `acc_void` is 1 for exactly one cycle, after the edge where entry begins, if `acc_busy` is 1 at that edge. It stays 0 if `acc_busy` is 0 at that edge, and it is never raised later in the entry phase.
- R7: If `sel_en`, `strobe_a` or `strobe_b` is 1 on an edge inside the recovery period, `proto_err` goes to 1 after that edge and stays at 1.
- R8: If `sel_en`, `strobe_a` or `strobe_b` is 1 on an edge while the sequencer is in the entry phase, `proto_err` goes to 1 after that edge.
- R9: Selects and strobes have no effect on `proto_err` while awake outside recovery, or while resting.
- R10: A request that lasts a single cycle still completes the whole sequence. After the entry phase, `sleep_active` is 1 for one cycle, and then the exit phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request, asynchronous, active high; tie low when unused |
| sel_en | input | 1 | Memory chip select seen by the array, active high |
| strobe_a | input | 1 | First address strobe, active high |
| strobe_b | input | 1 | Second address strobe, active high |
| acc_busy | input | 1 | An access is in flight, active high |
| sleep_active | output | 1 | Array rests while 1 |
| acc_block | output | 1 | New accesses must be inhibited while 1 |
| acc_void | output | 1 | One-cycle mark that the in-flight access was cut off |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
Every result has a fixed latency counted in registers. A change on the request reaches `acc_block` or the falling `sleep_active` three edges later: two synchroniser flops and then the sequencer register. `sleep_active` rises ENT_CYC edges after that, and `acc_block` clears REC_CYC edges after `sleep_active` falls. `acc_void` and `proto_err` are registered on the edge that samples their cause, so they show up one edge after the stimulus.

The bench applies every input row at a falling edge. It compares that row's expected outputs one time unit after the next rising edge, so each expectation names the exact edge where the value must appear. Reset, a violation during entry and a single-cycle request are covered by directed sequences after the table.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

    // Sequencer states; the encoding carries no external meaning.
    typedef enum logic [1:0] {
        LP_AWAKE  = 2'd0,
        LP_ENTER  = 2'd1,
        LP_ASLEEP = 2'd2,
        LP_EXIT   = 2'd3
    } lp_state_e;

endpackage

// File: rtl/lp_req_sync.sv
module lp_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    // Each stage takes the one before it; stage 0 takes the raw request.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sh_d[g] = async_in;
        end else begin : g_next
            assign sh_d[g] = sh_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/lp_recov_timer.sv
module lp_recov_timer #(
    parameter int CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = W'(CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

    // R5: a load always opens a recovery period on the next cycle.
    assert_load_opens_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/lp_sleep_seq.sv
module lp_sleep_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int ENT_CYC     = 2,
    parameter int EXIT_CYC    = 2,
    parameter int REC_CYC     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sel_en,
    input  logic strobe_a,
    input  logic strobe_b,
    input  logic acc_busy,
    output logic sleep_active,
    output logic acc_block,
    output logic acc_void,
    output logic proto_err
);

    import lp_sleep_pkg::*;

    localparam int STEP_MAX = (ENT_CYC > EXIT_CYC) ? ENT_CYC : EXIT_CYC;
    localparam int STEP_W   = $clog2(STEP_MAX + 1);

    typedef struct packed {
        lp_state_e         st;
        logic [STEP_W-1:0] step;
        logic              void_f;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d;
    seq_regs_t r_q;
    logic      req_s;
    logic      rec_load;
    logic      rec_busy;
    logic      bus_act;
    logic      viol_win;

    lp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    lp_recov_timer #(.CYC(REC_CYC)) u_recov (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rec_load),
        .busy  (rec_busy)
    );

    assign bus_act  = sel_en | strobe_a | strobe_b;
    assign viol_win = (r_q.st == LP_ENTER) | rec_busy;

    always_comb begin
        r_d        = r_q;
        r_d.void_f = 1'b0;
        rec_load   = 1'b0;
        unique case (r_q.st)
            LP_AWAKE: begin
                if (req_s) begin
                    r_d.st     = LP_ENTER;
                    r_d.step   = '0;
                    r_d.void_f = acc_busy;
                end
            end
            LP_ENTER: begin
                if (r_q.step == STEP_W'(ENT_CYC - 1)) begin
                    r_d.st = LP_ASLEEP;
                end else begin
                    r_d.step = r_q.step + STEP_W'(1);
                end
            end
            LP_ASLEEP: begin
                if (!req_s) begin
                    r_d.st   = LP_EXIT;
                    r_d.step = '0;
                    rec_load = 1'b1;
                end
            end
            LP_EXIT: begin
                if (r_q.step == STEP_W'(EXIT_CYC - 1)) begin
                    r_d.st = LP_AWAKE;
                end else begin
                    r_d.step = r_q.step + STEP_W'(1);
                end
            end
            default: r_d.st = LP_AWAKE;
        endcase
        if (viol_win && bus_act) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: LP_AWAKE, step: '0, void_f: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sleep_active = (r_q.st == LP_ASLEEP);
    assign acc_block    = (r_q.st != LP_AWAKE) | rec_busy;
    assign acc_void     = r_q.void_f;
    assign proto_err    = r_q.err;

    // R3: the array only starts resting straight out of the entry phase.
    assert_rest_follows_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> $past(r_q.st) == LP_ENTER);

    // R6: the void mark only appears in the first entry cycle.
    assert_void_only_entering_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_void |-> (r_q.st == LP_ENTER && r_q.step == '0));

    // R5: the inhibit is released only once fully awake.
    assert_release_only_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_block) |-> (r_q.st == LP_AWAKE && !sleep_active));

    // R7: the violation flag never clears without reset.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);

    // R4: leaving the resting state always enters the exit phase.
    assert_rest_leaves_to_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_active) |-> r_q.st == LP_EXIT);

endmodule

// File: tb/tb_lp_sleep_seq.sv
module tb_lp_sleep_seq;

    localparam int REC   = 4;
    localparam int NROWS = 29;

    logic clk = 1'b0;
    logic rst_n;
    logic sleep_req, sel_en, strobe_a, strobe_b, acc_busy;
    logic sleep_active, acc_block, acc_void, proto_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lp_sleep_seq #(.SYNC_STAGES(2), .ENT_CYC(2), .EXIT_CYC(2), .REC_CYC(REC)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sel_en       (sel_en),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .acc_busy     (acc_busy),
        .sleep_active (sleep_active),
        .acc_block    (acc_block),
        .acc_void     (acc_void),
        .proto_err    (proto_err)
    );

    // Row: {req, sel, strobe_a, strobe_b, busy, exp_block, exp_sleep, exp_void, exp_err}
    // Inputs are applied before an edge; expectations hold after that same edge.
    localparam logic [8:0] VEC [NROWS] = '{
        9'b00000_0000, 9'b01100_0000,                 // R9 awake traffic
        9'b10000_0000, 9'b10000_0000, 9'b10001_1010,  // R2 block at k+2, R6 void
        9'b10001_1000, 9'b10000_1100,                 // R6 no late void, R3 rest
        9'b11110_1100,                                // R9 traffic while resting
        9'b00000_1100, 9'b00000_1100, 9'b00000_1000,  // R4 rest ends at m+2
        9'b00000_1000, 9'b00000_1000, 9'b00000_1000,
        9'b00000_0000,                                // R5 release after REC
        9'b01000_0000,                                // R9 after window
        9'b10000_0000, 9'b10000_0000, 9'b10000_1000,
        9'b10000_1000, 9'b10000_1100, 9'b00000_1100,
        9'b00000_1100, 9'b00000_1000, 9'b00000_1000,
        9'b00000_1000,
        9'b00100_1001,                                // R7 strobe in recovery
        9'b00000_0001, 9'b00000_0001                  // R7 sticky
    };

    function automatic string row_tag(input int i);
        if (i < 2)       return "R9";
        else if (i < 4)  return "R2";
        else if (i == 4) return "R6";
        else if (i == 5) return "R6";
        else if (i == 6) return "R3";
        else if (i == 7) return "R9";
        else if (i < 14) return "R4";
        else if (i == 14) return "R5";
        else if (i == 15) return "R9";
        else if (i < 26) return "R4";
        else             return "R7";
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {acc_block, sleep_active, acc_void, proto_err};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {block,sleep,void,err} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [4:0] in, input logic [3:0] exp, input string tag);
        @(negedge clk);
        {sleep_req, sel_en, strobe_a, strobe_b, acc_busy} = in;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {sleep_req, sel_en, strobe_a, strobe_b, acc_busy} = 5'b0;
        @(posedge clk);
        #1;
        check(4'b0000, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(4'b0000, "R1");
    endtask

    initial begin
        rst_n = 1'b0;
        {sleep_req, sel_en, strobe_a, strobe_b, acc_busy} = 5'b0;
        repeat (3) @(negedge clk);
        check(4'b0000, "R1");
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            step(VEC[i][8:4], VEC[i][3:0], row_tag(i));
        end

        // R1: reset clears the sticky flag left by the table.
        do_reset();

        // R8: select asserted during the entry phase.
        step(5'b10000, 4'b0000, "R8");
        step(5'b10000, 4'b0000, "R8");
        step(5'b10000, 4'b1000, "R8");
        step(5'b11000, 4'b1001, "R8");
        step(5'b10000, 4'b1101, "R8");

        do_reset();

        // R10: a single-cycle request still runs the whole sequence.
        step(5'b10000, 4'b0000, "R10");
        step(5'b00000, 4'b0000, "R10");
        step(5'b00000, 4'b1000, "R10");
        step(5'b00000, 4'b1000, "R10");
        step(5'b00000, 4'b1100, "R10");
        step(5'b00000, 4'b1000, "R10");
        for (int j = 0; j < REC - 1; j++) begin
            step(5'b00000, 4'b1000, "R5");
        end
        step(5'b00000, 4'b0000, "R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule